// File: doc/BRIEF.md
# Dual-Set Pattern Bank Mapper

This block sits between a video fetch engine and a banked pattern memory. It turns each 14-bit pattern-side fetch address into a 1 KB physical bank number and a 10-bit in-bank offset. It keeps two groups of bank registers. The sprite group has eight registers and the background group has four. A granularity setting chooses 8 KB, 4 KB, 2 KB or 1 KB windows, and that setting applies to both groups.

Background fetches use the background group only when tall (double-height) sprites are enabled and the fetch engine is in its background phase. The phase is tracked from the dot counter on visible lines while rendering is on. A fetch marked as a sprite tile load always uses the sprite group. The tall-sprite flag is taken from writes to the display control register.

The raw 1 KB index is reduced modulo the number of installed banks, which is a parameter. An address with bit 13 set lies outside the pattern space, and the block flags it so that the data reads as zero. The pattern memory itself is outside the block.

Top module: `pbm_bank_map`

## Requirements
- R1: After reset, out_valid, bank_o, offset_o and zero_o are 0. The granularity is 8 KB. All sprite registers hold 0, the background registers 0..3 hold 0, 1, 2 and 3, and the upper-bits latch holds 0. The tall flag and the phase are 0, where phase 0 means background.
- R2: In 8 KB granularity (mode 0), the sprite group gives index = (sprite reg 7 << 3) + page, where page is fetch_addr[12:10].
- R3: In 4 KB granularity (mode 1), the sprite group gives (reg 3 << 2) + page[1:0] for pages 0..3 and (reg 7 << 2) + page[1:0] for pages 4..7.
- R4: In 2 KB granularity (mode 2), the sprite group gives (reg {page[2:1],1} << 1) + page[0]. In 1 KB granularity (mode 3), it gives reg[page].
- R5: Configuration writes use cfg_addr. Codes 0..7 write sprite regs 0..7. Codes 8..11 write background regs 0..3. Code 12 sets the granularity from cfg_wdata[1:0]. Code 13 sets the upper-bits latch from cfg_wdata[1:0]. Codes 14 and 15 change nothing.
- R6: The background group covers all eight pages. Mode 0 gives (bg3 << 3) + page. Mode 1 gives (bg3 << 2) + page[1:0]. Mode 2 gives ((page[1] ? bg3 : bg1) << 1) + page[0]. Mode 3 gives bg[page[1:0]].
- R7: The background group is used only when the tall flag is 1 and the phase is background. In every other case the sprite group is used.
- R8: A fetch with fetch_sprite high uses the sprite group whatever the tall flag and the phase are.
- R9: On a dot_tick with render_en and line_visible both high, dots 1 and 321 set the phase to background and dot 257 sets it to sprite. No other dot tick changes the phase.
- R10: Each stored bank value is 10 bits: {upper-bits latch, cfg_wdata}, captured when the bank register is written. A later change of the latch does not alter values already stored.
- R11: bank_o is the raw index modulo NUM_BANKS (default 200).
- R12: A fetch with fetch_addr[13] set gives zero_o = 1, bank_o = 0 and offset_o = 0.
- R13: out_valid, bank_o, offset_o and zero_o appear one clock after the fetch is presented. offset_o equals fetch_addr[9:0].
- R14: A write to the display control register (ctrl_we) loads the tall flag from ctrl_wdata[5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register code |
| cfg_wdata | input | 8 | Configuration write data |
| ctrl_we | input | 1 | Display control register write seen |
| ctrl_wdata | input | 8 | Display control write data (bit 5 = tall sprites) |
| render_en | input | 1 | Rendering enabled |
| line_visible | input | 1 | Current line is a visible line |
| dot_tick | input | 1 | A dot count is presented this cycle |
| dot | input | 9 | Dot number within the line |
| fetch_valid | input | 1 | Pattern fetch presented |
| fetch_addr | input | 14 | Pattern fetch address |
| fetch_sprite | input | 1 | Fetch is a sprite tile load |
| out_valid | output | 1 | Translation result valid |
| bank_o | output | clog2(NUM_BANKS) | Physical 1 KB bank |
| offset_o | output | 10 | Offset inside the bank |
| zero_o | output | 1 | Address outside pattern space, data reads as 0 |

## Verification
A translation result is registered once, so it is due exactly one clock after the fetch is presented. Register writes, control writes and dot ticks take effect at the edge that samples them, so they are seen by any fetch presented on a later cycle. The bench presents every stimulus on a falling edge and holds it for one cycle. It performs each operation in its own cycle and compares the outputs on the following falling edge, which is one cycle after the fetch. No check ever depends on an operation and a fetch sharing an edge.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
   typedef enum logic [1:0] {
      GRAN_8K = 2'd0,
      GRAN_4K = 2'd1,
      GRAN_2K = 2'd2,
      GRAN_1K = 2'd3
   } gran_e;

   localparam int unsigned PAGE_W = 3;
   localparam int unsigned OFFS_W = 10;
   localparam int unsigned FADDR_W = 14;
   localparam int unsigned CFG_AW = 4;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned SPR_REGS = 8;
   localparam int unsigned BG_REGS = 4;

   localparam logic [CFG_AW-1:0] CFG_GRAN = 4'd12;
   localparam logic [CFG_AW-1:0] CFG_HIGH = 4'd13;
endpackage

// File: rtl/pbm_regs.sv
module pbm_regs
   import pbm_pkg::*;
#(
   parameter int unsigned HI_W = 2,
   localparam int unsigned REG_W = DATA_W + HI_W
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cfg_we,
   input  logic [CFG_AW-1:0]                    cfg_addr,
   input  logic [DATA_W-1:0]                    cfg_wdata,
   output gran_e                                gran_q,
   output logic [SPR_REGS-1:0][REG_W-1:0]       spr_q,
   output logic [BG_REGS-1:0][REG_W-1:0]        bg_q
);
   logic [HI_W-1:0] hi_q;
   logic [REG_W-1:0] wval;

   assign wval = {hi_q, cfg_wdata};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gran_q <= GRAN_8K;
         hi_q   <= '0;
      end else if (cfg_we) begin
         if (cfg_addr == CFG_GRAN) gran_q <= gran_e'(cfg_wdata[1:0]);
         if (cfg_addr == CFG_HIGH) hi_q   <= cfg_wdata[HI_W-1:0];
      end
   end

   for (genvar gi = 0; gi < SPR_REGS; gi++) begin : g_spr
      always_ff @(posedge clk) begin
         if (!rst_n) spr_q[gi] <= '0;
         else if (cfg_we && cfg_addr == CFG_AW'(gi)) spr_q[gi] <= wval;
      end
   end

   for (genvar gj = 0; gj < BG_REGS; gj++) begin : g_bg
      always_ff @(posedge clk) begin
         if (!rst_n) bg_q[gj] <= REG_W'(gj);
         else if (cfg_we && cfg_addr == CFG_AW'(SPR_REGS + gj)) bg_q[gj] <= wval;
      end
   end

   // R5
   gran_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_addr == CFG_GRAN) |=> $stable(gran_q));

   // R10
   spr7_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == CFG_AW'(7)) |=> spr_q[7][DATA_W-1:0] == $past(cfg_wdata));
endmodule

// File: rtl/pbm_phase.sv
module pbm_phase
   import pbm_pkg::*;
#(
   parameter int unsigned DOT_W    = 9,
   parameter int unsigned TALL_BIT = 5,
   parameter int unsigned DOT_BG_A = 1,
   parameter int unsigned DOT_SPR  = 257,
   parameter int unsigned DOT_BG_B = 321
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] ctrl_wdata,
   input  logic              render_en,
   input  logic              line_visible,
   input  logic              dot_tick,
   input  logic [DOT_W-1:0]  dot,
   output logic              tall_q,
   output logic              spr_phase_q
);
   if (TALL_BIT >= DATA_W) begin : g_bad_bit
      $error("pbm_phase: TALL_BIT outside control byte");
   end
   if (DOT_BG_B >= (1 << DOT_W)) begin : g_bad_dot
      $error("pbm_phase: DOT_W too narrow for phase dots");
   end

   logic live;
   assign live = dot_tick && render_en && line_visible;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tall_q      <= 1'b0;
         spr_phase_q <= 1'b0;
      end else begin
         if (ctrl_we) tall_q <= ctrl_wdata[TALL_BIT];
         if (live) begin
            if (dot == DOT_W'(DOT_SPR)) spr_phase_q <= 1'b1;
            else if (dot == DOT_W'(DOT_BG_A) || dot == DOT_W'(DOT_BG_B)) spr_phase_q <= 1'b0;
         end
      end
   end

   // R9
   phase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dot_tick && render_en && line_visible) |=> $stable(spr_phase_q));

   // R9
   phase_spr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_tick && render_en && line_visible && dot == DOT_W'(DOT_SPR)) |=> spr_phase_q);

   // R14
   tall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> tall_q == $past(ctrl_wdata[TALL_BIT]));
endmodule

// File: rtl/pbm_setmap.sv
module pbm_setmap
   import pbm_pkg::*;
#(
   parameter int unsigned REG_W  = 10,
   parameter bit          BG_SET = 1'b0,
   parameter int unsigned NREG   = BG_SET ? BG_REGS : SPR_REGS,
   localparam int unsigned RAW_W = REG_W + PAGE_W
) (
   input  gran_e                         gran,
   input  logic [PAGE_W-1:0]             page,
   input  logic [NREG-1:0][REG_W-1:0]    regs,
   output logic [RAW_W-1:0]              raw
);
   if (BG_SET) begin : g_bg
      if (NREG != BG_REGS) begin : g_bad
         $error("pbm_setmap: background group needs four registers");
      end
      always_comb begin
         unique case (gran)
            GRAN_8K: raw = {regs[3], page};
            GRAN_4K: raw = {1'b0, regs[3], page[1:0]};
            GRAN_2K: raw = {2'b0, (page[1] ? regs[3] : regs[1]), page[0]};
            default: raw = {3'b0, regs[page[1:0]]};
         endcase
      end
   end else begin : g_spr
      if (NREG != SPR_REGS) begin : g_bad
         $error("pbm_setmap: sprite group needs eight registers");
      end
      always_comb begin
         unique case (gran)
            GRAN_8K: raw = {regs[7], page};
            GRAN_4K: raw = {1'b0, (page[2] ? regs[7] : regs[3]), page[1:0]};
            GRAN_2K: raw = {2'b0, regs[{page[2:1], 1'b1}], page[0]};
            default: raw = {3'b0, regs[page]};
         endcase
      end
   end
endmodule

// File: rtl/pbm_mod.sv
module pbm_mod #(
   parameter int unsigned IN_W  = 13,
   parameter int unsigned NUM   = 200,
   localparam int unsigned OUT_W = $clog2(NUM),
   localparam int unsigned WIDE  = IN_W + OUT_W + 1
) (
   input  logic [IN_W-1:0]  raw,
   output logic [OUT_W-1:0] rem
);
   if (NUM < 2) begin : g_bad
      $error("pbm_mod: NUM must be at least 2");
   end

   if ((NUM & (NUM - 1)) == 0) begin : g_pow2
      assign rem = raw[OUT_W-1:0];
   end else begin : g_sub
      logic [IN_W-1:0] r;
      always_comb begin
         r = raw;
         for (int i = IN_W - 1; i >= 0; i--) begin
            if (WIDE'(r) >= (WIDE'(NUM) << i)) begin
               r = r - IN_W'(WIDE'(NUM) << i);
            end
         end
      end
      assign rem = r[OUT_W-1:0];

      // R11
      always_comb begin
         rem_range_chk: assert (WIDE'(r) < WIDE'(NUM));
      end
   end
endmodule

// File: rtl/pbm_bank_map.sv
module pbm_bank_map
   import pbm_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 200,
   parameter int unsigned HI_W      = 2,
   parameter int unsigned DOT_W     = 9,
   parameter int unsigned TALL_BIT  = 5,
   parameter int unsigned DOT_BG_A  = 1,
   parameter int unsigned DOT_SPR   = 257,
   parameter int unsigned DOT_BG_B  = 321,
   localparam int unsigned REG_W    = DATA_W + HI_W,
   localparam int unsigned RAW_W    = REG_W + PAGE_W,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [3:0]         cfg_addr,
   input  logic [7:0]         cfg_wdata,
   input  logic               ctrl_we,
   input  logic [7:0]         ctrl_wdata,
   input  logic               render_en,
   input  logic               line_visible,
   input  logic               dot_tick,
   input  logic [DOT_W-1:0]   dot,
   input  logic               fetch_valid,
   input  logic [13:0]        fetch_addr,
   input  logic               fetch_sprite,
   output logic               out_valid,
   output logic [BANK_W-1:0]  bank_o,
   output logic [9:0]         offset_o,
   output logic               zero_o
);
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("pbm_bank_map: NUM_BANKS must be at least 2");
   end
   if (HI_W < 1) begin : g_bad_hi
      $error("pbm_bank_map: HI_W must be at least 1");
   end

   gran_e                              gran;
   logic [SPR_REGS-1:0][REG_W-1:0]     spr_regs;
   logic [BG_REGS-1:0][REG_W-1:0]      bg_regs;
   logic                               tall;
   logic                               spr_phase;
   logic [RAW_W-1:0]                   raw_spr, raw_bg, raw_sel;
   logic [BANK_W-1:0]                  bank_mod;
   logic                               use_bg;
   logic [PAGE_W-1:0]                  page;

   pbm_regs #(.HI_W(HI_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .gran_q    (gran),
      .spr_q     (spr_regs),
      .bg_q      (bg_regs)
   );

   pbm_phase #(
      .DOT_W    (DOT_W),
      .TALL_BIT (TALL_BIT),
      .DOT_BG_A (DOT_BG_A),
      .DOT_SPR  (DOT_SPR),
      .DOT_BG_B (DOT_BG_B)
   ) phase_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_we      (ctrl_we),
      .ctrl_wdata   (ctrl_wdata),
      .render_en    (render_en),
      .line_visible (line_visible),
      .dot_tick     (dot_tick),
      .dot          (dot),
      .tall_q       (tall),
      .spr_phase_q  (spr_phase)
   );

   assign page = fetch_addr[12:10];

   pbm_setmap #(.REG_W(REG_W), .BG_SET(1'b0)) spr_map_i (
      .gran (gran),
      .page (page),
      .regs (spr_regs),
      .raw  (raw_spr)
   );

   pbm_setmap #(.REG_W(REG_W), .BG_SET(1'b1)) bg_map_i (
      .gran (gran),
      .page (page),
      .regs (bg_regs),
      .raw  (raw_bg)
   );

   assign use_bg  = tall && !spr_phase && !fetch_sprite;
   assign raw_sel = use_bg ? raw_bg : raw_spr;

   pbm_mod #(.IN_W(RAW_W), .NUM(NUM_BANKS)) mod_i (
      .raw (raw_sel),
      .rem (bank_mod)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         bank_o    <= '0;
         offset_o  <= '0;
         zero_o    <= 1'b0;
      end else begin
         out_valid <= fetch_valid;
         if (fetch_valid) begin
            if (fetch_addr[13]) begin
               bank_o   <= '0;
               offset_o <= '0;
               zero_o   <= 1'b1;
            end else begin
               bank_o   <= bank_mod;
               offset_o <= fetch_addr[9:0];
               zero_o   <= 1'b0;
            end
         end
      end
   end

   // R13
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |=> out_valid);

   // R13
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !fetch_addr[13]) |=> (offset_o == $past(fetch_addr[9:0]) && !zero_o));

   // R11
   bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (32'(bank_o) < NUM_BANKS));

   // R12
   outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_addr[13]) |=> (zero_o && bank_o == '0 && offset_o == '0));
endmodule

// File: tb/pbm_bank_map_tb_top.sv
`timescale 1ns/1ps
module pbm_bank_map_tb_top;
   localparam int NB = 200;
   localparam int BW = $clog2(NB);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_addr = '0;
   logic [7:0]    cfg_wdata = '0;
   logic          ctrl_we = 1'b0;
   logic [7:0]    ctrl_wdata = '0;
   logic          render_en = 1'b0;
   logic          line_visible = 1'b0;
   logic          dot_tick = 1'b0;
   logic [8:0]    dot = '0;
   logic          fetch_valid = 1'b0;
   logic [13:0]   fetch_addr = '0;
   logic          fetch_sprite = 1'b0;
   logic          out_valid;
   logic [BW-1:0] bank_o;
   logic [9:0]    offset_o;
   logic          zero_o;

   int errors = 0;
   int checks = 0;

   int m_spr [8];
   int m_bg  [4];
   int m_gran, m_hi;
   bit m_tall, m_phase;

   always #2 clk = ~clk;

   pbm_bank_map #(.NUM_BANKS(NB)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .render_en(render_en),
      .line_visible(line_visible), .dot_tick(dot_tick), .dot(dot),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_sprite(fetch_sprite),
      .out_valid(out_valid), .bank_o(bank_o), .offset_o(offset_o), .zero_o(zero_o)
   );

   function automatic int exp_raw(int addr, bit spr_f);
      int pg;
      bit bg;
      pg = (addr >> 10) & 7;
      bg = m_tall && !m_phase && !spr_f;
      if (bg) begin
         case (m_gran)
            0: return (m_bg[3] << 3) + pg;
            1: return (m_bg[3] << 2) + (pg & 3);
            2: return (((pg & 2) != 0 ? m_bg[3] : m_bg[1]) << 1) + (pg & 1);
            default: return m_bg[pg & 3];
         endcase
      end else begin
         case (m_gran)
            0: return (m_spr[7] << 3) + pg;
            1: return ((pg >= 4 ? m_spr[7] : m_spr[3]) << 2) + (pg & 3);
            2: return (m_spr[(pg & 6) | 1] << 1) + (pg & 1);
            default: return m_spr[pg];
         endcase
      end
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 8; i++) m_spr[i] = 0;
      for (int i = 0; i < 4; i++) m_bg[i] = i;
      m_gran = 0; m_hi = 0; m_tall = 0; m_phase = 0;
   endtask

   task automatic cfg_write(int a, int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < 8) m_spr[a] = (m_hi << 8) | (d & 255);
      else if (a < 12) m_bg[a - 8] = (m_hi << 8) | (d & 255);
      else if (a == 12) m_gran = d & 3;
      else if (a == 13) m_hi = d & 3;
   endtask

   task automatic ctrl_write(int d);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = 8'(d);
      @(negedge clk);
      ctrl_we = 1'b0;
      m_tall = ((d >> 5) & 1) != 0;
   endtask

   task automatic dot_step(int d, bit ren, bit vis);
      @(negedge clk);
      dot_tick = 1'b1; dot = 9'(d); render_en = ren; line_visible = vis;
      @(negedge clk);
      dot_tick = 1'b0;
      if (ren && vis) begin
         if (d == 257) m_phase = 1;
         else if (d == 1 || d == 321) m_phase = 0;
      end
   endtask

   task automatic fetch_check(string tag, int addr, bit spr_f);
      int eb, eo, ez;
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 14'(addr); fetch_sprite = spr_f;
      if ((addr & 'h2000) != 0) begin
         eb = 0; eo = 0; ez = 1;
      end else begin
         eb = exp_raw(addr, spr_f) % NB; eo = addr & 1023; ez = 0;
      end
      @(negedge clk);
      fetch_valid = 1'b0; fetch_sprite = 1'b0;
      check({tag, " valid"}, int'(out_valid), 1);
      check({tag, " bank"}, int'(bank_o), eb);
      check({tag, " offset"}, int'(offset_o), eo);
      check({tag, " zero"}, int'(zero_o), ez);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0071));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 valid", int'(out_valid), 0);
      check("R1 bank", int'(bank_o), 0);
      check("R1 zero", int'(zero_o), 0);
      fetch_check("R1 sprite default", 'h1400, 0);
      ctrl_write('h20);
      fetch_check("R1 bg default", 'h1555, 0);
      // R14 tall flag follows bit 5 only
      ctrl_write('hDF);
      fetch_check("R14 tall cleared", 'h0C00, 0);
      ctrl_write('h20);
      // R2 mode 0 sprite
      ctrl_write('h00);
      cfg_write(7, 'h12);
      fetch_check("R2 mode0", 'h1800, 0);
      // R10 upper bits captured at write time
      cfg_write(13, 1);
      cfg_write(7, 'h05);
      fetch_check("R10 high bits", 'h0C33, 0);
      cfg_write(13, 0);
      fetch_check("R10 latch later", 'h0C33, 0);
      // R11 modulo with large raw index
      cfg_write(13, 3);
      cfg_write(7, 'hFF);
      fetch_check("R11 modulo max", 'h1FFF, 0);
      cfg_write(13, 0);
      // R3 mode 1
      cfg_write(12, 1);
      cfg_write(3, 'h21);
      cfg_write(7, 'h09);
      fetch_check("R3 low half", 'h0800, 0);
      fetch_check("R3 high half", 'h1C00, 0);
      // R4 mode 2 and mode 3
      cfg_write(12, 2);
      cfg_write(1, 'h11);
      cfg_write(5, 'h33);
      fetch_check("R4 mode2 p1", 'h0400, 0);
      fetch_check("R4 mode2 p5", 'h1400, 0);
      cfg_write(12, 3);
      for (int i = 0; i < 8; i++) cfg_write(i, 10 * i + 3);
      fetch_check("R4 mode3 p6", 'h1800, 0);
      // R5 ignored codes leave everything unchanged
      cfg_write(14, 'hFF);
      cfg_write(15, 'hFF);
      fetch_check("R5 ignored codes", 'h1800, 0);
      // R6 background set in all four modes
      ctrl_write('h20);
      for (int i = 0; i < 4; i++) cfg_write(8 + i, 'h40 + 7 * i);
      for (int g = 0; g < 4; g++) begin
         cfg_write(12, g);
         fetch_check("R6 bg lo", 'h0400, 0);
         fetch_check("R6 bg hi", 'h1C00, 0);
      end
      // R8 sprite strobe overrides
      fetch_check("R8 sprite strobe", 'h1C00, 1);
      // R9 / R7 phase handling
      dot_step(257, 0, 1);
      fetch_check("R9 render off", 'h0400, 0);
      dot_step(257, 1, 0);
      fetch_check("R9 not visible", 'h0400, 0);
      dot_step(257, 1, 1);
      fetch_check("R7 sprite phase", 'h0400, 0);
      dot_step(100, 1, 1);
      fetch_check("R9 other dot", 'h0400, 0);
      dot_step(321, 1, 1);
      fetch_check("R9 dot 321", 'h0400, 0);
      dot_step(257, 1, 1);
      dot_step(1, 1, 1);
      fetch_check("R9 dot 1", 'h0400, 0);
      // R12 outside pattern space
      fetch_check("R12 outside", 'h2ABC, 0);
      fetch_check("R12 top", 'h3FFF, 1);
      // random mix
      for (int n = 0; n < 800; n++) begin
         int op;
         op = int'($urandom % 10);
         if (op < 2) cfg_write(int'($urandom % 16), int'($urandom % 256));
         else if (op == 2) ctrl_write(int'($urandom % 256));
         else if (op == 3) begin
            int sel, d;
            sel = int'($urandom % 4);
            d = (sel == 0) ? 1 : (sel == 1) ? 257 : (sel == 2) ? 321 : int'($urandom % 341);
            dot_step(d, 1'($urandom % 4 != 0), 1'($urandom % 4 != 0));
         end else begin
            int a;
            a = int'($urandom % 'h2000);
            if ($urandom % 16 == 0) a = a | 'h2000;
            fetch_check((m_tall && !m_phase) ? "R6 R7 random" : "R2 R13 random", a, 1'($urandom % 4 == 0));
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule